// File: doc/BRIEF.md
# Data-Strobe Receive Clock Recovery with Pulse Filter

This block rebuilds the receive clock of a serial link that uses data-strobe signalling, where on every bit boundary exactly one of the two lines toggles. Two recovery channels share four input lines. Each channel takes its data and strobe from one fixed pair of lines. Each channel samples its pair with a fast oversampling clock through a flop synchronizer, forms the exclusive-OR of the two synchronized lines, and passes that level through a minimum-width filter. Only the filtered level is driven out as the recovered clock.

Received data is taken on both rising and falling transitions of the filtered clock, inside the oversampling domain. A separate output mirrors the raw data line feeding each channel. A configuration check makes sure two channels cannot claim the same pair of lines. The recovered clock stays low after reset until a real transition has been seen on the selected lines.

Top module: `ds_clk_recover`

## Requirements
- R1: While `rst_n` is low at a rising edge, every `rec_clk` and `rec_data` bit is 0 after that edge, and filter and arming state are cleared.
- R2: For an enabled and armed channel, `rec_clk` follows data XOR strobe. A change that holds on the pads is seen at `rec_clk` after the (SYNC_STAGES + STABLE_CYCLES)-th rising edge, counting the first edge that samples it (4 edges with defaults).
- R3: A change of the XOR level that lasts fewer than STABLE_CYCLES consecutive oversample cycles never reaches `rec_clk`. Each new `rec_clk` level therefore holds for at least two cycles. A pulse of exactly STABLE_CYCLES cycles does pass.
- R4: `ch_pair[c]` = 0 selects data from `pad_in[1]` and strobe from `pad_in[0]`. `ch_pair[c]` = 1 selects data from `pad_in[3]` and strobe from `pad_in[2]`.
- R5: `cfg_conflict` is 1 exactly when two enabled channels select the same pair. The lower-numbered channel then keeps the pair, and the higher-numbered one behaves as disabled (R9).
- R6: On every rising edge where `rec_clk` changes level, in either direction, `rec_data` takes the synchronized data line as it stood before that edge. At all other edges `rec_data` holds.
- R7: `raw_data[c]` combinationally equals the data pad selected for channel c while the channel is effectively enabled, and 0 otherwise.
- R8: After reset or after enabling, `rec_clk` stays 0 until a level change on the channel's data or strobe line has passed through the synchronizer. A line that is simply held high does not raise the clock.
- R9: A channel that is not effectively enabled at an edge is cleared at that edge, in the same way as by R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_in | input | 4 | Asynchronous serial input lines |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_pair | input | NUM_CH | Per-channel line-pair select (R4) |
| rec_clk | output | NUM_CH | Filtered recovered clock per channel |
| rec_data | output | NUM_CH | Data captured on recovered clock transitions |
| raw_data | output | NUM_CH | Mirror of the data line feeding each channel |
| cfg_conflict | output | 1 | Two enabled channels claim one pair |

## Verification
A recovered clock transition and a data capture always fall in the same cycle. The pulse filter can also suppress a transition in the very cycle a channel is disabled or a pair conflict appears. The bench drives data-strobe bit streams, single-cycle and two-cycle strobe glitches, and random toggling combined with random enable and pair changes. This creates collisions between filter flips, captures and channel clears. A behavioural model keeps per-channel pad histories and a run-length counter, and predicts every output. All outputs are compared against that model one nanosecond after every rising edge.

// File: rtl/ds_rec_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and pair decoding for the data-strobe recovery block.
// Assumes four input lines arranged as two strobe/data pairs.
package ds_rec_pkg;
    localparam int PAD_COUNT = 4;

    typedef enum logic {
        PAIR_LO = 1'b0,   // data on line 1, strobe on line 0
        PAIR_HI = 1'b1    // data on line 3, strobe on line 2
    } pair_e;

    // Index of the data line of a pair (always odd).
    function automatic int data_idx(pair_e p);
        return (p == PAIR_LO) ? 1 : 3;
    endfunction

    // Index of the strobe line of a pair (even line just below the data line).
    function automatic int strobe_idx(pair_e p);
        return data_idx(p) - 1;
    endfunction
endpackage

// File: rtl/ds_pair_select.sv
`timescale 1ns/1ps
// Module: ds_pair_select
// Routes each channel's data/strobe lines from the pad inputs and resolves
// pair conflicts: a lower-numbered enabled channel wins a shared pair.
// Assumes: purely combinational, pad_in already at block boundary.
module ds_pair_select
    import ds_rec_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic [PAD_COUNT-1:0] pad_in,
    input  logic [NUM_CH-1:0]    ch_en,
    input  logic [NUM_CH-1:0]    ch_pair,
    output logic [NUM_CH-1:0]    sel_data,
    output logic [NUM_CH-1:0]    sel_strobe,
    output logic [NUM_CH-1:0]    eff_en,
    output logic                 conflict
);
    logic [NUM_CH-1:0] lose;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Pick the data and strobe lines named by this channel's pair code.
        always_comb begin
            sel_data[c]   = pad_in[data_idx(pair_e'(ch_pair[c]))];
            sel_strobe[c] = pad_in[strobe_idx(pair_e'(ch_pair[c]))];
        end

        // Detect whether an enabled lower channel already claims this pair.
        always_comb begin
            lose[c] = 1'b0;
            for (int j = 0; j < c; j++) begin
                if (ch_en[j] && ch_en[c] && (ch_pair[j] == ch_pair[c])) begin
                    lose[c] = 1'b1;
                end
            end
        end

        // A channel runs only when enabled and not displaced.
        always_comb eff_en[c] = ch_en[c] && !lose[c];
    end

    // Any displaced channel means an illegal configuration.
    always_comb conflict = |lose;
endmodule

// File: rtl/ds_sync_arm.sv
`timescale 1ns/1ps
// Module: ds_sync_arm
// Synchronizes one data/strobe pair into the oversampling domain and arms
// the channel once a genuine level change has been observed on either line.
// Assumes SYNC_STAGES >= 2; clr is a synchronous per-channel clear.
module ds_sync_arm #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic data_in,
    input  logic strobe_in,
    output logic data_s,
    output logic strobe_s,
    output logic armed
);
    localparam int VW = $clog2(SYNC_STAGES + 2);
    localparam logic [VW-1:0] VFULL = VW'(SYNC_STAGES + 1);

    logic [SYNC_STAGES-1:0] dchain_q;
    logic [SYNC_STAGES-1:0] schain_q;
    logic                   dprev_q;
    logic                   sprev_q;
    logic [VW-1:0]          vcnt_q;
    logic                   armed_q;

    // Shift both lines through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dchain_q <= '0;
            schain_q <= '0;
        end else begin
            dchain_q <= {dchain_q[SYNC_STAGES-2:0], data_in};
            schain_q <= {schain_q[SYNC_STAGES-2:0], strobe_in};
        end
    end

    always_comb begin
        data_s   = dchain_q[SYNC_STAGES-1];
        strobe_s = schain_q[SYNC_STAGES-1];
    end

    // Keep last synchronized values and count cycles until history is real.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dprev_q <= 1'b0;
            sprev_q <= 1'b0;
            vcnt_q  <= '0;
        end else begin
            dprev_q <= data_s;
            sprev_q <= strobe_s;
            if (vcnt_q != VFULL) vcnt_q <= vcnt_q + 1'b1;
        end
    end

    // Arm once a real transition is seen on either synchronized line.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            armed_q <= 1'b0;
        end else if ((vcnt_q == VFULL) &&
                     ((data_s != dprev_q) || (strobe_s != sprev_q))) begin
            armed_q <= 1'b1;
        end
    end

    always_comb armed = armed_q;
endmodule

// File: rtl/ds_glitch_filter.sv
`timescale 1ns/1ps
// Module: ds_glitch_filter
// Minimum-width filter on the combined clock level, plus data capture on
// each accepted transition of the filtered clock.
// Assumes STABLE_CYCLES >= 2; clr is a synchronous per-channel clear.
module ds_glitch_filter #(
    parameter int STABLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic level_in,
    input  logic data_in,
    output logic rec_clk,
    output logic rec_data
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;
    logic          data_q;
    logic          differ;
    logic          flip;

    // Decide whether the input level has been held long enough to accept.
    always_comb begin
        differ = (level_in != filt_q);
        flip   = differ && (cnt_q == LAST);
    end

    // Count the run of mismatching cycles and accept on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
            data_q <= 1'b0;
        end else if (flip) begin
            cnt_q  <= '0;
            filt_q <= level_in;
            data_q <= data_in;
        end else if (differ) begin
            cnt_q  <= cnt_q + 1'b1;
        end else begin
            cnt_q  <= '0;
        end
    end

    always_comb begin
        rec_clk  = filt_q;
        rec_data = data_q;
    end

    // R3: an accepted level is never replaced on the very next edge.
    p_min_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(filt_q) && !clr) |=> $stable(filt_q))
        else $error("p_min_width_r3 violated");

    // R6: data moves only together with a filtered clock transition.
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(clr) && $stable(filt_q)) |-> $stable(data_q))
        else $error("p_capture_r6 violated");
endmodule

// File: rtl/ds_clk_recover.sv
`timescale 1ns/1ps
// Module: ds_clk_recover (top)
// Data-strobe clock recovery for NUM_CH channels sharing four input lines:
// pair routing and conflict check, synchronizer with arming, XOR combine,
// minimum-width filter and data capture.
// Assumes clk oversamples the link well above the bit rate.
module ds_clk_recover
    import ds_rec_pkg::*;
#(
    parameter int NUM_CH        = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PAD_COUNT-1:0] pad_in,
    input  logic [NUM_CH-1:0]    ch_en,
    input  logic [NUM_CH-1:0]    ch_pair,
    output logic [NUM_CH-1:0]    rec_clk,
    output logic [NUM_CH-1:0]    rec_data,
    output logic [NUM_CH-1:0]    raw_data,
    output logic                 cfg_conflict
);
    logic [NUM_CH-1:0] sel_data;
    logic [NUM_CH-1:0] sel_strobe;
    logic [NUM_CH-1:0] eff_en;
    logic [NUM_CH-1:0] data_s;
    logic [NUM_CH-1:0] strobe_s;
    logic [NUM_CH-1:0] armed;
    logic [NUM_CH-1:0] level;

    ds_pair_select #(.NUM_CH(NUM_CH)) u_select (
        .pad_in    (pad_in),
        .ch_en     (ch_en),
        .ch_pair   (ch_pair),
        .sel_data  (sel_data),
        .sel_strobe(sel_strobe),
        .eff_en    (eff_en),
        .conflict  (cfg_conflict)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ds_sync_arm #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (!eff_en[c]),
            .data_in  (sel_data[c]),
            .strobe_in(sel_strobe[c]),
            .data_s   (data_s[c]),
            .strobe_s (strobe_s[c]),
            .armed    (armed[c])
        );

        // Combine the lines; hold low until the channel has armed.
        always_comb level[c] = armed[c] & (data_s[c] ^ strobe_s[c]);

        ds_glitch_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filter (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (!eff_en[c]),
            .level_in(level[c]),
            .data_in (data_s[c]),
            .rec_clk (rec_clk[c]),
            .rec_data(rec_data[c])
        );

        // Mirror the data line actually feeding this channel.
        always_comb raw_data[c] = eff_en[c] & sel_data[c];

        // R8: no clock activity before the channel has armed.
        p_quiet_until_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !armed[c] |-> !rec_clk[c])
            else $error("p_quiet_until_armed_r8 violated");
    end

    if (NUM_CH >= 2) begin : g_conf_chk
        // R5: under a conflict the highest channel cannot own the shared pair.
        p_conflict_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_conflict && (ch_pair[0] == ch_pair[NUM_CH-1])) |-> !raw_data[NUM_CH-1])
            else $error("p_conflict_quiet_r5 violated");
    end
endmodule

// File: tb/ds_clk_recover_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural per-channel history model compared after every edge.
module ds_clk_recover_tb_top;
    localparam int NCH = 2;
    localparam int SYN = 2;
    localparam int STB = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     pads = '0;
    logic [NCH-1:0] en = '0;
    logic [NCH-1:0] sel = '0;
    logic [NCH-1:0] rec_clk, rec_data, raw_data;
    logic           conflict;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    ds_clk_recover #(.NUM_CH(NCH), .SYNC_STAGES(SYN), .STABLE_CYCLES(STB)) dut_i (
        .clk(clk), .rst_n(rst_n), .pad_in(pads), .ch_en(en), .ch_pair(sel),
        .rec_clk(rec_clk), .rec_data(rec_data), .raw_data(raw_data),
        .cfg_conflict(conflict)
    );

    // Model state: pad history shift words (bit j = value j edges ago), edge count.
    logic [7:0] dh [NCH];
    logic [7:0] sh [NCH];
    int         kc [NCH];
    int         run [NCH];
    bit         m_arm [NCH];
    bit         m_clk [NCH];
    bit         m_dat [NCH];

    function automatic bit eff_of(int c);
        if (c == 0) return en[0];
        return en[1] && !(en[0] && (sel[0] == sel[1]));
    endfunction

    function automatic bit dpad_of(int c);
        return sel[c] ? pads[3] : pads[1];
    endfunction

    function automatic bit spad_of(int c);
        return sel[c] ? pads[2] : pads[0];
    endfunction

    task automatic model_step();
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n || !eff_of(c)) begin
                dh[c] = '0; sh[c] = '0; kc[c] = 0; run[c] = 0;
                m_arm[c] = 0; m_clk[c] = 0; m_dat[c] = 0;
            end else begin
                bit lvl;
                bit arm_next;
                kc[c]++;
                dh[c] = {dh[c][6:0], dpad_of(c)};
                sh[c] = {sh[c][6:0], spad_of(c)};
                lvl = m_arm[c] ? (dh[c][SYN] ^ sh[c][SYN]) : 1'b0;
                arm_next = m_arm[c];
                if (kc[c] >= SYN + 2 &&
                    (dh[c][SYN] != dh[c][SYN+1] || sh[c][SYN] != sh[c][SYN+1]))
                    arm_next = 1;
                if (lvl != m_clk[c]) begin
                    run[c]++;
                    if (run[c] == STB) begin
                        m_clk[c] = lvl;
                        m_dat[c] = dh[c][SYN];
                        run[c] = 0;
                    end
                end else begin
                    run[c] = 0;
                end
                m_arm[c] = arm_next;
            end
        end
    endtask

    task automatic compare();
        bit exp_conf;
        vectors++;
        exp_conf = en[0] && en[1] && (sel[0] == sel[1]);
        if (conflict !== exp_conf) begin
            fails++;
            $display("FAIL %s/R5 cfg_conflict act=%0b exp=%0b t=%0t", cur_req, conflict, exp_conf, $time);
        end
        for (int c = 0; c < NCH; c++) begin
            bit exp_raw;
            exp_raw = eff_of(c) ? dpad_of(c) : 1'b0;
            if (rec_clk[c] !== m_clk[c]) begin
                fails++;
                $display("FAIL %s rec_clk[%0d] act=%0b exp=%0b t=%0t", cur_req, c, rec_clk[c], m_clk[c], $time);
            end
            if (rec_data[c] !== m_dat[c]) begin
                fails++;
                $display("FAIL %s/R6 rec_data[%0d] act=%0b exp=%0b t=%0t", cur_req, c, rec_data[c], m_dat[c], $time);
            end
            if (raw_data[c] !== exp_raw) begin
                fails++;
                $display("FAIL %s/R7 raw_data[%0d] act=%0b exp=%0b t=%0t", cur_req, c, raw_data[c], exp_raw, $time);
            end
        end
    endtask

    // Advance the model at each edge, then compare once outputs settle.
    always @(posedge clk) begin
        cycles++;
        model_step();
        #1 compare();
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // Data-strobe encode one bit on a pair: toggle data if bit differs, else strobe.
    task automatic ds_bit(int pair, bit b, int period);
        @(negedge clk);
        if (pair == 0) begin
            if (pads[1] != b) pads[1] = b; else pads[0] = ~pads[0];
        end else begin
            if (pads[3] != b) pads[3] = b; else pads[2] = ~pads[2];
        end
        wait_n(period - 1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        // Watchdog: a hung run counts as a failed check.
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state.
        cur_req = "R1";
        wait_n(5);
        @(negedge clk) rst_n = 1'b1;
        wait_n(3);

        // R8: lines held at a static level after enabling must not raise the clock.
        cur_req = "R8";
        @(negedge clk) begin pads = 4'b1010; en = 2'b11; sel = 2'b10; end
        wait_n(12);

        // R2/R6: data-strobe bit streams on both pairs.
        cur_req = "R2";
        for (int i = 0; i < 40; i++) begin
            ds_bit(0, bit'((i * 7 + 3) % 5 > 1), 6);
        end
        cur_req = "R6";
        for (int i = 0; i < 30; i++) begin
            ds_bit(1, bit'((i * 5 + 1) % 3 == 0), 5);
        end

        // R3: one-cycle glitch is rejected, two-cycle pulse passes.
        cur_req = "R3";
        @(negedge clk) pads[0] = ~pads[0];
        @(negedge clk) pads[0] = ~pads[0];
        wait_n(8);
        @(negedge clk) pads[0] = ~pads[0];
        wait_n(1);
        @(negedge clk) pads[0] = ~pads[0];
        wait_n(8);
        @(negedge clk) pads[2] = ~pads[2];
        @(negedge clk) pads[2] = ~pads[2];
        wait_n(8);

        // R4: swap pairs between channels.
        cur_req = "R4";
        @(negedge clk) sel = 2'b01;
        for (int i = 0; i < 20; i++) begin
            ds_bit(i % 2, bit'(i % 3 == 0), 6);
        end

        // R5: both channels claim one pair.
        cur_req = "R5";
        @(negedge clk) sel = 2'b00;
        for (int i = 0; i < 16; i++) ds_bit(0, bit'(i % 2), 6);
        @(negedge clk) sel = 2'b11;
        for (int i = 0; i < 16; i++) ds_bit(1, bit'(i % 4 == 1), 6);

        // R9: disabling a channel clears it.
        cur_req = "R9";
        @(negedge clk) begin en = 2'b01; sel = 2'b10; end
        for (int i = 0; i < 10; i++) ds_bit(0, bit'(i % 3 == 1), 5);
        @(negedge clk) en = 2'b10;
        wait_n(6);

        // Mixed: random toggling with random configuration changes.
        cur_req = "R3";
        @(negedge clk) en = 2'b11;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            pads = pads ^ 4'($urandom_range(0, 15) & $urandom_range(0, 15) & $urandom_range(0, 15));
            if (i % 97 == 50) begin
                en  = 2'($urandom_range(0, 3));
                sel = 2'($urandom_range(0, 3));
            end
        end

        // R1: reset in the middle of activity.
        cur_req = "R1";
        @(negedge clk) rst_n = 1'b0;
        wait_n(3);
        @(negedge clk) rst_n = 1'b1;
        wait_n(6);
        finish_run();
    end
endmodule